// File: doc/BRIEF.md
# Parallel Display Bus Transfer Engine

This block moves pixel and command traffic between a host register port and an external display controller over an 8- or 16-bit parallel bus. The host loads 32-bit words into a small transmit FIFO. The engine cuts each word into narrower bus picks and drives each pick for one bus cycle. Each cycle has a programmable strobe-low phase and a programmable strobe-high recovery phase. In read direction the same cycles pulse a read strobe and pack the sampled picks back into 32-bit words in a receive FIFO.

A transfer runs for a programmed number of bus cycles. A command/data level is held on its own pin for the whole transfer, and chip select stays low from the start of the transfer to its end. The host starts a transfer by clearing a chip-select bit and a write-enable bit, and sets them again to re-arm or abort. The host can poll a status bit to see whether the engine is idle. A DMA request line can be enabled; it stays raised while the transmit FIFO has room. An identity register returns an alternating probe pattern followed by a component code and a version.

Register map (word addresses): 0 identity, 1 transfer configuration, 2 control/status, 3 pick format, 4 FIFO port, 5 tick divider.

Top module: `dbus_engine`

## Requirements
- R1: Writing any value to address 0 restarts the identity sequence. The next reads return 32'h55555555, then 32'hAAAAAAAA, then the COMP_CODE parameter, then {VER_MAJOR[15:0], VER_MINOR[15:0]}. That last value repeats on any further reads.
- R2: After reset:
  - busCsN, busWrN and busRdN are high and dmaReq is low.
  - Address 2 reads 0x18: write-enable bit 4 is set and idle bit 3 is set.
- R3: Timing inside a transfer:
  - Each bus cycle starts with the strobe high. The strobe goes low exactly one bus tick after the cycle starts; for the first cycle, that is one tick after chip select falls.
  - The strobe stays low for config[23:20]+1 ticks.
  - A whole cycle lasts that active length plus the recovery length, which is config[29:24]+1 ticks.
- R4: One bus tick lasts divider[2:0]+1 clock cycles, where the divider register is at address 5.
- R5: A recovery length below 3 ticks is raised to 3 ticks.
- R6: Each transmit word leaves as pick[9:5]+1 picks of pick[4:0]+1 bits each, least-significant pick first.
  - The pick register is at address 3.
  - A word is removed from the FIFO after its last pick.
  - Writes to address 4 fill the transmit FIFO.
- R7: A transfer ends after exactly config[17:0]+1 bus cycles:
  - chip select rises and address 2 bit 3 reads 1, even if transmit data remains;
  - the next transfer begins at the first pick of the head word.
- R8: busCmdData equals config bit 18 (0 = command, 1 = data) during every strobe of the transfer.
- R9: Starting and aborting a transfer:
  - A transfer starts when address 2 bit 0 (enable) is 1 and config bit 30 and address 2 bit 4 both become 0.
  - With enable at 0 nothing starts.
  - Setting config bit 30 during a transfer aborts it, and chip select is high two clocks after the write.
- R10: With address 2 bit 2 set, the engine pulses busRdN instead of busWrN.
  - It samples busDin at the last clock of each low phase.
  - It packs the picks least-significant first into receive FIFO words, which are read at address 4.
  - Reading address 4 with the receive FIFO empty returns 0.
- R11: dmaReq is high exactly when enable is set, config bit 19 is set and the transmit FIFO is not full.
- R12: If a write cycle would start with the transmit FIFO empty, the engine waits at the cycle start with chip select low and the strobe high until a word arrives.
- R13: While address 2 bit 1 (soft reset) is set, both FIFOs are emptied and any running transfer stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (advances identity, pops receive FIFO) |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| busDin | input | BUS_W | Parallel bus input data |
| busDout | output | BUS_W | Parallel bus output data (current pick) |
| busDoutEn | output | 1 | Output-enable for busDout during write transfers |
| busCmdData | output | 1 | Command (0) / data (1) level |
| busCsN | output | 1 | Chip select, active low |
| busWrN | output | 1 | Write strobe, active low |
| busRdN | output | 1 | Read strobe, active low |
| dmaReq | output | 1 | Request for more transmit words |

## Verification
A scoreboard predicts every pick from the pushed words and the pick format. A wrong unpacking order or a missed FIFO pop therefore shows up as a mismatched byte or halfword. The monitor measures the strobe-low width, the cycle period and the delay from chip select to the first strobe. It does this with the divider at 1 and at 3 and with recovery programmed below the minimum, so an off-by-one in any tick counter, or a missing floor of 3 ticks, changes a measured length. Other tests end a transfer with data still queued, start with an empty FIFO, abort midway and flush with soft reset. A design that kept strobing past the cycle count, resumed mid-word, strobed on empty data or kept stale FIFO contents would produce extra, missing or wrong picks. The read test checks that sampled bytes are packed least-significant first.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  localparam int LEN_W   = 18;
  localparam int PICK_FW = 5;
  localparam int PHASE_W = 7;

  localparam logic [2:0] ADDR_ID   = 3'd0;
  localparam logic [2:0] ADDR_CFG  = 3'd1;
  localparam logic [2:0] ADDR_CTL  = 3'd2;
  localparam logic [2:0] ADDR_PICK = 3'd3;
  localparam logic [2:0] ADDR_FIFO = 3'd4;
  localparam logic [2:0] ADDR_DIV  = 3'd5;

  localparam logic [31:0] PROBE_A = 32'h5555_5555;
  localparam logic [31:0] PROBE_B = 32'hAAAA_AAAA;

  // configuration seen by the sequencer
  typedef struct packed {
    logic [3:0]         actTicksM1;
    logic [5:0]         recTicksM1;
    logic [2:0]         divSel;
    logic [LEN_W-1:0]   lastCycle;
    logic [PICK_FW-1:0] pickCountM1;
    logic               readMode;
    logic               go;
  } seqCfg_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic               popTx;
    logic               pushRx;
    logic               capture;
    logic               clearAsm;
    logic [PICK_FW-1:0] pickIdx;
    logic               active;
  } seqStrb_t;
endpackage

// File: rtl/dbus_fifo.sv
module dbus_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      fill;
  logic             doPush, doPop;

  assign empty    = (fill == '0);
  assign full     = (fill == (AW+1)'(DEPTH));
  assign doPush   = push & ~full & ~flush;
  assign doPop    = pop & ~empty & ~flush;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == AW'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == AW'(DEPTH-1)) ? '0 : rdPtr + 1'b1;
      fill <= fill + {{AW{1'b0}}, doPush} - {{AW{1'b0}}, doPop};
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/dbus_datapath.sv
module dbus_datapath
  import dbus_pkg::*;
#(
  parameter int          BUS_W     = 16,
  parameter int          TX_DEPTH  = 4,
  parameter int          RX_DEPTH  = 4,
  parameter logic [31:0] COMP_CODE = 32'h0000_0D1B,
  parameter int          VER_MAJOR = 1,
  parameter int          VER_MINOR = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [BUS_W-1:0] busDin,
  output logic [BUS_W-1:0] busDout,
  output logic             busDoutEn,
  output logic             busCmdData,
  output logic             dmaReq,
  input  seqStrb_t         strb,
  output seqCfg_t          cfg,
  output logic             txEmpty,
  output logic             rxFull
);
  localparam logic [31:0] VERSION = {16'(VER_MAJOR), 16'(VER_MINOR)};

  logic [31:0]        cfgReg;
  logic               ctlEnable, ctlSoftRst, ctlReadMode, ctlWeN;
  logic [PICK_FW-1:0] pickWidthM1, pickCountM1;
  logic [2:0]         divReg;
  logic [1:0]         idSeq;
  logic [31:0]        asmWord;

  logic        wrHit, rdHit;
  logic        txFull, rxEmpty;
  logic [31:0] txHead, rxHead;
  logic [31:0] idWord;
  logic [5:0]  pickWidth;
  logic [9:0]  shAmt;
  logic [31:0] widthMask;
  logic [31:0] inData;

  assign wrHit = regWrEn;
  assign rdHit = regRdEn;

  // host registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg      <= 32'h4000_0000;
      ctlEnable   <= 1'b0;
      ctlSoftRst  <= 1'b0;
      ctlReadMode <= 1'b0;
      ctlWeN      <= 1'b1;
      pickWidthM1 <= 5'd7;
      pickCountM1 <= 5'd3;
      divReg      <= 3'd0;
    end else if (wrHit) begin
      case (regAddr)
        ADDR_CFG:  cfgReg <= regWdata;
        ADDR_CTL: begin
          ctlEnable   <= regWdata[0];
          ctlSoftRst  <= regWdata[1];
          ctlReadMode <= regWdata[2];
          ctlWeN      <= regWdata[4];
        end
        ADDR_PICK: begin
          pickWidthM1 <= regWdata[4:0];
          pickCountM1 <= regWdata[9:5];
        end
        ADDR_DIV:  divReg <= regWdata[2:0];
        default: ;
      endcase
    end
  end

  // identity probe sequence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idSeq <= 2'd0;
    else if (wrHit && regAddr == ADDR_ID) idSeq <= 2'd0;
    else if (rdHit && regAddr == ADDR_ID && idSeq != 2'd3) idSeq <= idSeq + 2'd1;
  end

  always_comb begin
    case (idSeq)
      2'd0:    idWord = PROBE_A;
      2'd1:    idWord = PROBE_B;
      2'd2:    idWord = COMP_CODE;
      default: idWord = VERSION;
    endcase
  end

  // FIFOs
  dbus_fifo #(.WIDTH(32), .DEPTH(TX_DEPTH)) txFifo (
    .clk(clk), .rstN(rstN), .flush(ctlSoftRst),
    .push(wrHit && regAddr == ADDR_FIFO), .pushData(regWdata),
    .pop(strb.popTx), .headData(txHead), .empty(txEmpty), .full(txFull)
  );

  dbus_fifo #(.WIDTH(32), .DEPTH(RX_DEPTH)) rxFifo (
    .clk(clk), .rstN(rstN), .flush(ctlSoftRst),
    .push(strb.pushRx), .pushData(asmWord),
    .pop(rdHit && regAddr == ADDR_FIFO), .headData(rxHead), .empty(rxEmpty), .full(rxFull)
  );

  // pick selection
  assign pickWidth = {1'b0, pickWidthM1} + 6'd1;
  assign shAmt     = 10'(strb.pickIdx) * 10'(pickWidth);
  assign widthMask = (pickWidth >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << pickWidth) - 32'd1);
  assign busDout   = BUS_W'((txHead >> shAmt) & widthMask);
  assign inData    = 32'(busDin) & widthMask;

  // read word assembly
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) asmWord <= '0;
    else if (strb.clearAsm || strb.pushRx) asmWord <= '0;
    else if (strb.capture) asmWord <= asmWord | (inData << shAmt);
  end

  // read mux
  always_comb begin
    case (regAddr)
      ADDR_ID:   regRdata = idWord;
      ADDR_CFG:  regRdata = cfgReg;
      ADDR_CTL:  regRdata = {27'd0, ctlWeN, ~strb.active, ctlReadMode, ctlSoftRst, ctlEnable};
      ADDR_PICK: regRdata = {22'd0, pickCountM1, pickWidthM1};
      ADDR_FIFO: regRdata = rxEmpty ? 32'd0 : rxHead;
      ADDR_DIV:  regRdata = {29'd0, divReg};
      default:   regRdata = 32'd0;
    endcase
  end

  assign busCmdData = cfgReg[18];
  assign busDoutEn  = strb.active & ~ctlReadMode;
  assign dmaReq     = ctlEnable & cfgReg[19] & ~txFull;

  always_comb begin
    cfg.actTicksM1  = cfgReg[23:20];
    cfg.recTicksM1  = cfgReg[29:24];
    cfg.divSel      = divReg;
    cfg.lastCycle   = cfgReg[LEN_W-1:0];
    cfg.pickCountM1 = pickCountM1;
    cfg.readMode    = ctlReadMode;
    cfg.go          = ctlEnable & ~ctlSoftRst & ~cfgReg[30] & ~ctlWeN;
  end
endmodule

// File: rtl/dbus_ctrl.sv
module dbus_ctrl
  import dbus_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  seqCfg_t  cfg,
  input  logic     txEmpty,
  input  logic     rxFull,
  output seqStrb_t strb,
  output logic     busCsN,
  output logic     busWrN,
  output logic     busRdN
);
  localparam logic [PHASE_W-1:0] MIN_REC = PHASE_W'(3);

  logic               active, goPrev;
  logic [2:0]         divCnt;
  logic [PHASE_W-1:0] phase;
  logic [LEN_W-1:0]   cycCnt;
  logic [PICK_FW-1:0] pickIdx;

  logic [PHASE_W-1:0] actLen, recRaw, recLen, lastPhase;
  logic tick, startEv, stall, endCycle, lastPick, lastCyc, strobeLow;

  assign actLen    = PHASE_W'(cfg.actTicksM1) + 1'b1;
  assign recRaw    = PHASE_W'(cfg.recTicksM1) + 1'b1;
  assign recLen    = (recRaw < MIN_REC) ? MIN_REC : recRaw;
  assign lastPhase = actLen + recLen - 1'b1;

  assign tick     = active & (divCnt == cfg.divSel);
  assign startEv  = cfg.go & ~goPrev & ~active;
  assign stall    = (phase == '0) & (cfg.readMode ? rxFull : txEmpty);
  assign endCycle = tick & (phase == lastPhase);
  assign lastPick = (pickIdx == cfg.pickCountM1);
  assign lastCyc  = (cycCnt == cfg.lastCycle);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      goPrev  <= 1'b0;
      divCnt  <= '0;
      phase   <= '0;
      cycCnt  <= '0;
      pickIdx <= '0;
    end else begin
      goPrev <= cfg.go;
      if (!cfg.go) begin
        active <= 1'b0;
      end else if (startEv) begin
        active  <= 1'b1;
        divCnt  <= '0;
        phase   <= '0;
        cycCnt  <= '0;
        pickIdx <= '0;
      end else if (active) begin
        divCnt <= tick ? '0 : divCnt + 3'd1;
        if (tick && !stall) begin
          if (endCycle) begin
            phase   <= '0;
            cycCnt  <= cycCnt + 1'b1;
            pickIdx <= lastPick ? '0 : pickIdx + 1'b1;
            if (lastCyc) active <= 1'b0;
          end else begin
            phase <= phase + 1'b1;
          end
        end
      end
    end
  end

  assign strobeLow = active & (phase != '0) & (phase <= actLen);

  always_comb begin
    strb.popTx    = endCycle & cfg.go & ~cfg.readMode & lastPick;
    strb.pushRx   = endCycle & cfg.go & cfg.readMode & (lastPick | lastCyc);
    strb.capture  = tick & cfg.go & cfg.readMode & (phase == actLen);
    strb.clearAsm = startEv;
    strb.pickIdx  = pickIdx;
    strb.active   = active;
  end

  assign busCsN = ~active;
  assign busWrN = ~(strobeLow & ~cfg.readMode);
  assign busRdN = ~(strobeLow & cfg.readMode);
endmodule

// File: rtl/dbus_engine.sv
module dbus_engine
  import dbus_pkg::*;
#(
  parameter int          BUS_W     = 16,
  parameter int          TX_DEPTH  = 4,
  parameter int          RX_DEPTH  = 4,
  parameter logic [31:0] COMP_CODE = 32'h0000_0D1B,
  parameter int          VER_MAJOR = 1,
  parameter int          VER_MINOR = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [2:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [BUS_W-1:0] busDin,
  output logic [BUS_W-1:0] busDout,
  output logic             busDoutEn,
  output logic             busCmdData,
  output logic             busCsN,
  output logic             busWrN,
  output logic             busRdN,
  output logic             dmaReq
);
  seqCfg_t  cfg;
  seqStrb_t strb;
  logic     txEmpty, rxFull;

  dbus_datapath #(
    .BUS_W(BUS_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH),
    .COMP_CODE(COMP_CODE), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .busDin(busDin), .busDout(busDout), .busDoutEn(busDoutEn),
    .busCmdData(busCmdData), .dmaReq(dmaReq), .strb(strb), .cfg(cfg),
    .txEmpty(txEmpty), .rxFull(rxFull)
  );

  dbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .txEmpty(txEmpty), .rxFull(rxFull),
    .strb(strb), .busCsN(busCsN), .busWrN(busWrN), .busRdN(busRdN)
  );
endmodule

// File: rtl/dbus_chk.sv
module dbus_chk (
  input logic clk,
  input logic rstN,
  input logic busCsN,
  input logic busWrN,
  input logic busRdN,
  input logic busDoutEn
);
  // R3
  strobe_inside_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    busCsN |-> (busWrN && busRdN));

  // R10
  one_strobe_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!busWrN && !busRdN));

  // R3
  strobe_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busCsN) |-> (busWrN && busRdN));

  // R5
  min_recovery_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWrN) |=> busWrN);

  // R10
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDoutEn |-> (!busCsN && busRdN));
endmodule

bind dbus_engine dbus_chk u_chk (
  .clk(clk), .rstN(rstN), .busCsN(busCsN), .busWrN(busWrN),
  .busRdN(busRdN), .busDoutEn(busDoutEn)
);

// File: tb/tb_dbus_engine.sv
module tb_dbus_engine;
  localparam int CLK_PERIOD = 10;
  localparam int BUS_W = 16;
  localparam int TX_DEPTH = 4;
  localparam logic [31:0] COMP = 32'h0000_0D1B;
  localparam logic [31:0] VER  = 32'h0002_0007;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic [BUS_W-1:0] busDin = '0, busDout;
  logic busDoutEn, busCmdData, busCsN, busWrN, busRdN, dmaReq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbus_engine #(.BUS_W(BUS_W), .TX_DEPTH(TX_DEPTH), .RX_DEPTH(4),
                .COMP_CODE(COMP), .VER_MAJOR(2), .VER_MINOR(7)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .busDin(busDin), .busDout(busDout), .busDoutEn(busDoutEn),
    .busCmdData(busCmdData), .busCsN(busCsN), .busWrN(busWrN),
    .busRdN(busRdN), .dmaReq(dmaReq)
  );

  int checks = 0, fails = 0;
  logic [16:0] expQ[$];
  logic [15:0] rdQ[$];
  int tickNo = 0, csFallAt = 0, lastFall = 0, lowStart = 0;
  int wrCount = 0, rdCount = 0;
  bit firstPending = 0, chkTiming = 0, sbOn = 1;
  int expLead = 1, expLow = 1, expPeriod = 4;
  logic prevCs = 1'b1, prevWr = 1'b1, prevRd = 1'b1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard pop and strobe timing
  always @(negedge clk) begin
    tickNo++;
    if (prevCs && !busCsN) begin csFallAt = tickNo; firstPending = 1; end
    if (prevWr && !busWrN) begin
      wrCount++;
      if (chkTiming) begin
        if (firstPending) check(tickNo - csFallAt == expLead, "R3 first strobe delay", tickNo - csFallAt, expLead);
        else check(tickNo - lastFall == expPeriod, "R3/R4/R5 cycle period", tickNo - lastFall, expPeriod);
      end
      firstPending = 0;
      lastFall = tickNo;
      lowStart = tickNo;
      if (sbOn) begin
        if (expQ.size() == 0) check(0, "R6/R12 unexpected strobe", {15'd0, busCmdData, busDout}, 0);
        else begin
          logic [16:0] e;
          e = expQ.pop_front();
          check({busCmdData, busDout} == e, "R6/R8 pick data", {15'd0, busCmdData, busDout}, {15'd0, e});
        end
      end
    end
    if (!prevWr && busWrN && chkTiming)
      check(tickNo - lowStart == expLow, "R3/R4 strobe low width", tickNo - lowStart, expLow);
    if (prevRd && !busRdN) begin
      rdCount++;
      busDin = (rdQ.size() != 0) ? rdQ.pop_front() : 16'hDEAD;
    end
    prevCs = busCsN; prevWr = busWrN; prevRd = busRdN;
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; #1 d = regRdata;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  // driver: predict picks of a word
  task automatic expectPicks(input logic [31:0] w, input int width, input int first, input int count, input logic cmd);
    for (int i = first; i < first + count; i++) begin
      logic [31:0] m = (32'd1 << width) - 32'd1;
      expQ.push_back({cmd, 16'((w >> (i * width)) & m)});
    end
  endtask

  task automatic startXfer(input logic [31:0] c);
    regWrite(3'd1, c | 32'h4000_0000);
    regWrite(3'd1, c & ~32'h4000_0000);
  endtask

  task automatic waitCsHigh();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (busCsN) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state
    check(busCsN && busWrN && busRdN, "R2 bus idle after reset", {busCsN, busWrN, busRdN}, 3'b111);
    check(dmaReq == 1'b0, "R2 dmaReq after reset", dmaReq, 0);
    regRead(3'd2, d);
    check(d == 32'h18, "R2 control reset value", d, 32'h18);
    // R1 identity sequence
    regWrite(3'd0, 32'h0);
    regRead(3'd0, d); check(d == 32'h5555_5555, "R1 probe A", d, 32'h5555_5555);
    regRead(3'd0, d); check(d == 32'hAAAA_AAAA, "R1 probe B", d, 32'hAAAA_AAAA);
    regRead(3'd0, d); check(d == COMP, "R1 component", d, COMP);
    regRead(3'd0, d); check(d == VER, "R1 version", d, VER);
    regRead(3'd0, d); check(d == VER, "R1 version repeat", d, VER);

    // R6/R7/R3: 8-bit picks, div 1, active 2, recovery 4, 6 cycles
    regWrite(3'd2, 32'h01);
    regWrite(3'd3, 32'h67);
    regWrite(3'd5, 32'h0);
    regWrite(3'd4, 32'h4433_2211);
    regWrite(3'd4, 32'h8877_6655);
    expectPicks(32'h4433_2211, 8, 0, 4, 1'b1);
    expectPicks(32'h8877_6655, 8, 0, 2, 1'b1);
    expLead = 1; expLow = 2; expPeriod = 6; chkTiming = 1;
    base = wrCount;
    startXfer((32'd3 << 24) | (32'd1 << 20) | (32'd1 << 18) | 32'd5);
    waitCsHigh();
    check(busCsN == 1'b1, "R7 chip select released", busCsN, 1);
    check(wrCount - base == 6, "R7 cycle count with data left", wrCount - base, 6);
    check(expQ.size() == 0, "R6 all picks seen", expQ.size(), 0);
    regRead(3'd2, d);
    check(d[3] == 1'b1, "R7 idle bit after transfer", d[3], 1);
    // R7 restart at pick 0 of the head word, R8 command level
    expectPicks(32'h8877_6655, 8, 0, 4, 1'b0);
    base = wrCount;
    startXfer((32'd3 << 24) | (32'd1 << 20) | 32'd3);
    waitCsHigh();
    check(wrCount - base == 4, "R7 second transfer length", wrCount - base, 4);
    check(expQ.size() == 0, "R7 leftover word restarted", expQ.size(), 0);

    // R4/R5: 16-bit picks, div 3, active 3, recovery field 0 -> 3
    regWrite(3'd3, 32'h2F);
    regWrite(3'd5, 32'h2);
    regWrite(3'd4, 32'hBEEF_1234);
    regWrite(3'd4, 32'h0F0F_A5A5);
    expectPicks(32'hBEEF_1234, 16, 0, 2, 1'b1);
    expectPicks(32'h0F0F_A5A5, 16, 0, 2, 1'b1);
    expLead = 3; expLow = 9; expPeriod = 18;
    base = wrCount;
    startXfer((32'd2 << 20) | (32'd1 << 18) | 32'd3);
    waitCsHigh();
    check(wrCount - base == 4, "R4 16-bit cycle count", wrCount - base, 4);
    check(expQ.size() == 0, "R6 16-bit picks seen", expQ.size(), 0);

    // R12 stall on empty FIFO
    chkTiming = 0;
    regWrite(3'd3, 32'h67);
    regWrite(3'd5, 32'h0);
    base = wrCount;
    startXfer((32'd1 << 24) | (32'd1 << 18) | 32'd3);
    repeat (30) @(negedge clk);
    check(wrCount == base && busCsN == 1'b0, "R12 waits with strobe high", wrCount - base, 0);
    expectPicks(32'hA1B2_C3D4, 8, 0, 4, 1'b1);
    regWrite(3'd4, 32'hA1B2_C3D4);
    waitCsHigh();
    check(wrCount - base == 4, "R12 resumes after data", wrCount - base, 4);
    check(expQ.size() == 0, "R12 picks after stall", expQ.size(), 0);

    // R9 enable low blocks start
    regWrite(3'd2, 32'h00);
    base = wrCount;
    startXfer(32'd3);
    repeat (10) @(negedge clk);
    check(busCsN == 1'b1 && wrCount == base, "R9 no start while disabled", busCsN, 1);
    // R9 abort
    regWrite(3'd1, 32'h4000_0000);
    regWrite(3'd2, 32'h01);
    sbOn = 0;
    regWrite(3'd4, 32'h1111_1111);
    regWrite(3'd4, 32'h2222_2222);
    startXfer(32'd100);
    repeat (15) @(negedge clk);
    regWrite(3'd1, 32'h4000_0064);
    @(negedge clk);
    check(busCsN == 1'b1, "R9 abort releases chip select", busCsN, 1);
    base = wrCount;
    repeat (20) @(negedge clk);
    check(wrCount == base, "R9 no strobes after abort", wrCount - base, 0);

    // R13/R11 soft reset and DMA request
    regWrite(3'd1, 32'h4008_0000);
    regWrite(3'd2, 32'h03);
    regWrite(3'd2, 32'h01);
    @(negedge clk);
    check(dmaReq == 1'b1, "R13 flush frees space / R11 request", dmaReq, 1);
    for (int i = 0; i < TX_DEPTH; i++) regWrite(3'd4, 32'h100 + i);
    @(negedge clk);
    check(dmaReq == 1'b0, "R11 request drops when full", dmaReq, 0);
    regWrite(3'd2, 32'h03);
    @(negedge clk);
    check(dmaReq == 1'b1, "R13 soft reset empties FIFO", dmaReq, 1);
    regWrite(3'd2, 32'h01);
    regWrite(3'd1, 32'h4000_0000);
    @(negedge clk);
    check(dmaReq == 1'b0, "R11 request off when disabled in config", dmaReq, 0);
    sbOn = 1;

    // R10 read transfer
    regWrite(3'd2, 32'h05);
    rdQ.push_back(16'h11); rdQ.push_back(16'h22); rdQ.push_back(16'h33); rdQ.push_back(16'h44);
    base = wrCount;
    startXfer((32'd1 << 24) | (32'd1 << 18) | 32'd3);
    waitCsHigh();
    check(wrCount == base, "R10 no write strobe in read", wrCount - base, 0);
    regRead(3'd4, d);
    check(d == 32'h4433_2211, "R10 packed read word", d, 32'h4433_2211);
    regRead(3'd4, d);
    check(d == 32'h0, "R10 empty receive FIFO reads 0", d, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule